// File: doc/BRIEF.md
# Four-Mode 8-bit Adder/Subtractor

A purely combinational arithmetic unit that takes two 8-bit operands and a 2-bit mode code. It returns an 8-bit result together with two flags. The first flag is the carry out of the top bit. The second is the carry across the boundary between the low and the high nibble. In subtract modes both flags use the inverted-borrow convention: 1 means no borrow was needed. Operand B is always the base operand.

Internally the second operand comes from a per-bit 2:1 multiplexer, which picks either operand A or the constant one. A per-bit XOR then conditionally inverts that choice, and the result feeds a ripple chain of single-bit full adders. Mode bit 1 drives both the inversion and the carry into bit 0, which turns the chain into a two's-complement subtractor. The block holds no state and has no clock. It is meant to sit inside a datapath whose flag logic consumes both carries.

Top module: `addsub_unit`

## Requirements
- R1: With mode_i = 2'b00, result_o equals (b_i + a_i) mod 256.
- R2: With mode_i = 2'b01, result_o equals (b_i + 1) mod 256, and a_i has no effect on any output.
- R3: With mode_i = 2'b10, result_o equals (b_i - a_i) mod 256.
- R4: With mode_i = 2'b11, result_o equals (b_i - 1) mod 256, and a_i has no effect on any output.
- R5: In modes 00 and 01, c_o is the carry out of bit 7. In modes 10 and 11, c_o is 1 exactly when b_i is not less than the subtrahend (A, or 1), that is, when no borrow occurred.
- R6: dc_o follows the convention of R5 for bits 3..0 alone. For adds it is 1 when the low-nibble sum exceeds 15. For subtracts it is 1 when b_i[3:0] is not less than the low nibble of the subtrahend.
- R7: All outputs depend only on the present inputs, and they settle with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | Second operand (ignored in modes 01 and 11) |
| b_i | input | 8 | Base operand / minuend |
| mode_i | input | 2 | 00 add, 01 increment, 10 subtract, 11 decrement |
| result_o | output | 8 | Arithmetic result modulo 256 |
| c_o | output | 1 | Carry out of bit 7 / inverted borrow |
| dc_o | output | 1 | Carry out of bit 3 / inverted nibble borrow |

## Verification
Random operands rarely give a nibble carry with no full carry, or a subtraction whose nibbles are exactly equal. So the stimulus adds directed pairs that sit on those edges: equal low nibbles, and operands that differ only in the high nibble. The increment and decrement modes are wrap boundaries at 0xFF and 0x00, so those values of B are driven on purpose. To show that A is ignored in those modes, the bench drives A to two opposite values on the same B and compares the outputs directly.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic [1:0] {
    MODE_ADD = 2'b00,
    MODE_INC = 2'b01,
    MODE_SUB = 2'b10,
    MODE_DEC = 2'b11
  } mode_e;
endpackage

// File: rtl/fa_cell.sv
module fa_cell (
  input  logic x_i,
  input  logic y_i,
  input  logic ci_i,
  output logic s_o,
  output logic co_o
);
  logic p;
  assign p    = x_i ^ y_i;
  assign s_o  = p ^ ci_i;
  assign co_o = (x_i & y_i) | (p & ci_i);
endmodule

// File: rtl/operand_sel.sv
module operand_sel #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic             pick_one_i,
  input  logic             invert_i,
  output logic [WIDTH-1:0] op_o
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic sel;
    assign sel     = pick_one_i ? ONE[i] : a_i[i];
    assign op_o[i] = sel ^ invert_i;
  end

  // R2/R4: a constant operand must not carry any bit of A
  always_comb begin
    if (pick_one_i) begin
      p_const_op_r2: assert ((op_o ^ {WIDTH{invert_i}}) == ONE)
        else $error("constant operand corrupted");
    end
  end
endmodule

// File: rtl/ripple_chain.sv
module ripple_chain #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned NIB   = 4
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             cnib_o
);
  logic [WIDTH:0] carry;
  assign carry[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    fa_cell u_fa (
      .x_i (x_i[i]),
      .y_i (y_i[i]),
      .ci_i(carry[i]),
      .s_o (sum_o[i]),
      .co_o(carry[i+1])
    );
  end

  assign cout_o = carry[WIDTH];
  assign cnib_o = carry[NIB];

  // R6: nibble carry against a wide add of the low bits
  always_comb begin
    p_nib_carry_r6: assert (cnib_o ==
      ((({1'b0, x_i[NIB-1:0]} + {1'b0, y_i[NIB-1:0]} + {{NIB{1'b0}}, cin_i}) >> NIB) != 0))
      else $error("nibble carry mismatch");
  end
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned NIB   = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       mode_i,
  output logic [WIDTH-1:0] result_o,
  output logic             c_o,
  output logic             dc_o
);
  logic [WIDTH-1:0] op;
  mode_e            mode;
  assign mode = mode_e'(mode_i);

  operand_sel #(.WIDTH(WIDTH)) u_sel (
    .a_i       (a_i),
    .pick_one_i(mode_i[0]),
    .invert_i  (mode_i[1]),
    .op_o      (op)
  );

  ripple_chain #(.WIDTH(WIDTH), .NIB(NIB)) u_chain (
    .x_i   (b_i),
    .y_i   (op),
    .cin_i (mode_i[1]),
    .sum_o (result_o),
    .cout_o(c_o),
    .cnib_o(dc_o)
  );

  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  always_comb begin
    unique case (mode)
      MODE_ADD: p_add_r1: assert ({c_o, result_o} == {1'b0, b_i} + {1'b0, a_i})
                  else $error("add mismatch");
      MODE_INC: p_inc_r2: assert ({c_o, result_o} == {1'b0, b_i} + {1'b0, ONE})
                  else $error("increment mismatch");
      MODE_SUB: begin
        p_sub_r3: assert (result_o == WIDTH'(b_i - a_i)) else $error("subtract mismatch");
        p_borrow_r5: assert (c_o == (b_i >= a_i)) else $error("borrow flag mismatch");
      end
      MODE_DEC: begin
        p_dec_r4: assert (result_o == WIDTH'(b_i - ONE)) else $error("decrement mismatch");
        p_dec_borrow_r5: assert (c_o == (b_i != '0)) else $error("decrement flag mismatch");
      end
      default: ;
    endcase
  end
endmodule

// File: tb/addsub_unit_tb.sv
module addsub_unit_tb;
  logic       clk = 1'b0;
  logic [7:0] a, b, res;
  logic [1:0] m;
  logic       c, dc;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  addsub_unit u_dut (
    .a_i(a), .b_i(b), .mode_i(m),
    .result_o(res), .c_o(c), .dc_o(dc)
  );

  function automatic logic [9:0] model(input logic [7:0] fa, input logic [7:0] fb,
                                       input logic [1:0] fm);
    int sub, r;
    logic ec, edc;
    sub = fm[0] ? 1 : int'(fa);
    if (!fm[1]) begin
      r   = int'(fb) + sub;
      ec  = r > 255;
      edc = (int'(fb[3:0]) + (sub % 16)) > 15;
    end else begin
      r   = int'(fb) - sub;
      ec  = int'(fb) >= sub;
      edc = int'(fb[3:0]) >= (sub % 16);
    end
    return {ec, edc, r[7:0]};
  endfunction

  task automatic check(input string tag, input logic [9:0] exp);
    n_run++;
    if ({c, dc, res} !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h m=%b got c=%b dc=%b r=%h exp c=%b dc=%b r=%h",
               tag, a, b, m, c, dc, res, exp[9], exp[8], exp[7:0]);
    end
  endtask

  task automatic apply(input logic [7:0] ta, input logic [7:0] tb_, input logic [1:0] tm);
    @(negedge clk);
    a = ta; b = tb_; m = tm;
    #1;
  endtask

  function automatic string tag_of(input logic [1:0] fm);
    case (fm)
      2'b00: return "R1/R5/R6";
      2'b01: return "R2/R5/R6";
      2'b10: return "R3/R5/R6";
      default: return "R4/R5/R6";
    endcase
  endfunction

  task automatic vec(input logic [7:0] ta, input logic [7:0] tb_, input logic [1:0] tm);
    apply(ta, tb_, tm);
    check(tag_of(tm), model(ta, tb_, tm));
  endtask

  initial begin
    logic [9:0] first;
    void'($urandom(32'h5eed_0042));
    // R7: zero inputs, no clock edge needed
    a = 8'h00; b = 8'h00; m = 2'b00;
    #1 check("R7 idle", 10'b0_0_00000000);
    a = 8'h0F; b = 8'hF0; #1 check("R7 comb", {1'b0, 1'b0, 8'hFF});
    // directed vectors
    apply(8'h0F, 8'hF0, 2'b00); check("R1", {1'b0, 1'b0, 8'hFF});
    apply(8'h59, 8'h39, 2'b00); check("R1 R6", {1'b0, 1'b1, 8'h92});
    apply(8'h59, 8'h7F, 2'b01); check("R2", {1'b0, 1'b1, 8'h80});
    apply(8'h0F, 8'hF0, 2'b10); check("R3", {1'b1, 1'b0, 8'hE1});
    apply(8'h95, 8'h39, 2'b10); check("R3 R5", {1'b0, 1'b1, 8'hA4});
    apply(8'h95, 8'h80, 2'b11); check("R4", {1'b1, 1'b0, 8'h7F});
    // wrap and nibble boundaries
    apply(8'h00, 8'hFF, 2'b01); check("R2 wrap", {1'b1, 1'b1, 8'h00});
    apply(8'h00, 8'h00, 2'b11); check("R4 wrap", {1'b0, 1'b0, 8'hFF});
    apply(8'h37, 8'h37, 2'b10); check("R3 equal", {1'b1, 1'b1, 8'h00});
    apply(8'h45, 8'h25, 2'b10); check("R5 borrow R6 nonib", {1'b0, 1'b1, 8'hE0});
    apply(8'h08, 8'h08, 2'b00); check("R6 nib only", {1'b0, 1'b1, 8'h10});
    apply(8'h80, 8'h80, 2'b00); check("R5 carry only", {1'b1, 1'b0, 8'h00});
    // R2/R4: A ignored in constant modes
    for (int k = 0; k < 32; k++) begin
      logic [7:0] bb;
      logic [1:0] mm;
      bb = 8'($urandom);
      mm = (k % 2 == 0) ? 2'b01 : 2'b11;
      apply(8'h00, bb, mm);
      first = {c, dc, res};
      apply(8'hFF, bb, mm);
      check(mm[1] ? "R4 A ignored" : "R2 A ignored", first);
      check(mm[1] ? "R4 model" : "R2 model", model(8'h00, bb, mm));
    end
    // random sweep over every mode
    for (int k = 0; k < 2000; k++)
      vec(8'($urandom), 8'($urandom), 2'(k % 4));
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule